// File: doc/BRIEF.md
# Low-Power Mode Entry/Exit Controller

This block decides which low-power state a processor core enters when it executes its halt instruction, and it governs the way back out. A one-cycle sleep request is qualified by three configuration bits: standby select, low-speed select and watchdog prescaler select. The request then leads to one of three outcomes. In sleep only the CPU clock is gated. In software standby the CPU clock, the peripheral clocks and the oscillator are all stopped. Any other combination of the three bits leaves the core running.

Each state has its own set of wake sources. Sleep ends on any enabled interrupt that the CPU has not masked, and that set includes internal peripheral interrupts. Standby ends only on external sources: the non-maskable interrupt, enabled IRQ lines, enabled key-input lines, enabled wake-up lines, and the keyboard-interface interrupt. A standby exit first restarts the oscillator and then waits out a settling time chosen by a 3-bit field before the CPU clock returns. Entering standby raises a one-cycle strobe that resets the peripherals whose state is not kept. The reset pin overrides every other input. The core leaves reset only after the pin has been held low for a minimum time.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: With `stbySel`=0 and `lowSpdSel`=0, a `sleepReq` pulse in the running state gives `cpuClkEn`=0, `perClkEn`=1 and `oscEn`=1 from the next cycle on.
- R2: In sleep, the next edge returns the core to running when any of these is present: `nmi`, an IRQ line with its enable bit set, a key line with its enable bit set, a wake-up line with its enable bit set, `kbdIrq`, or `periphIrq`. Every source except `nmi` is blocked while `cpuMaskAll`=1.
- R3: With `stbySel`=1, `lowSpdSel`=0 and `wdtPssSel`=0, a `sleepReq` pulse gives `cpuClkEn`=`perClkEn`=`oscEn`=0 from the next cycle on. `perRstPulse` is high for exactly that first standby cycle.
- R4: In standby, the wake set is the set of R2 without `periphIrq`. An IRQ, key or wake-up line wakes the core only when its own enable bit is 1, and `cpuMaskAll`=1 blocks every source except `nmi`.
- R5: A standby wake raises `oscEn` on the next edge. The clocks then stay off for exactly N cycles before `cpuClkEn` returns. N is 8192, 16384, 32768, 65536, 131072 or 262144 for `settleSel` 0 to 5, 2048 for 6 and 16 for 7.
- R6: A `sleepReq` with any other configuration has no effect: `cpuClkEn` stays 1 and `perRstPulse` stays 0.
- R7: `wakeStart` is a one-cycle pulse in the first cycle in which `cpuClkEn` is high again after being low.
- R8: `rstPinN`=0 in any state gives `cpuClkEn`=0, `perClkEn`=1 and `oscEn`=1 from the next edge. Running resumes, with `wakeStart`, on the edge after the pin returns high, but only if the pin was low on at least `RST_MIN_CYC` consecutive edges. A shorter low period leaves the core held in reset.
- R9: `perRstPulse` is never raised on entry to sleep, nor at any time other than standby entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstPinN | input | 1 | Reset pin, active low |
| sleepReq | input | 1 | One-cycle pulse when the halt instruction executes |
| stbySel | input | 1 | Standby select bit |
| lowSpdSel | input | 1 | Low-speed select bit |
| wdtPssSel | input | 1 | Watchdog prescaler select bit |
| settleSel | input | 3 | Oscillator settling-time select |
| nmi | input | 1 | Non-maskable interrupt |
| irqReq | input | IRQ_W | IRQ request lines |
| irqEn | input | IRQ_W | IRQ enable bits |
| kinReq | input | KIN_W | Key-input lines |
| kinEn | input | KIN_W | Key-input enables |
| wueReq | input | WUE_W | Wake-up input lines |
| wueEn | input | WUE_W | Wake-up input enables |
| kbdIrq | input | 1 | Keyboard-interface interrupt |
| periphIrq | input | 1 | Internal peripheral interrupt, already enabled |
| cpuMaskAll | input | 1 | CPU masks all maskable interrupts |
| cpuClkEn | output | 1 | CPU clock enable |
| perClkEn | output | 1 | Peripheral clock enable |
| oscEn | output | 1 | Oscillator enable |
| perRstPulse | output | 1 | Reset strobe for the peripherals that are not retained |
| wakeStart | output | 1 | Exception-start pulse on return to running |

## Verification
Random trials pick the configuration bits with a bias toward the two valid codes, so that sleep, standby and the ignored combinations all appear. Each trial then applies exactly one wake source, with random enables and a random CPU mask. This separates the two wake sets: the same peripheral interrupt must wake sleep and must leave standby untouched, and a disabled or masked line must never wake either state while `nmi` always does. Directed cases cover the long settling codes, a reset pin that is released one cycle short of the minimum against one released at exactly the minimum, and a reset arriving during standby.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_SLEEP,
    ST_STBY,
    ST_SETTLE,
    ST_RESET
  } pwrState_e;

  // strobes from the control FSM into the datapath
  typedef struct packed {
    logic settleLoad;
    logic settleDec;
    logic rstStart;
    logic rstInc;
    logic rstClr;
  } dpCtl_t;

  localparam int SETTLE_W = 19;

  // settling length in cycles for each select code
  function automatic logic [SETTLE_W-1:0] settleCycles(input logic [2:0] sel);
    logic [SETTLE_W-1:0] v;
    case (sel)
      3'd6:    v = SETTLE_W'(2048);
      3'd7:    v = SETTLE_W'(16);
      default: v = SETTLE_W'(1) << (5'd13 + {2'b00, sel});
    endcase
    return v;
  endfunction

endpackage

// File: rtl/pwr_mode_dp.sv
module pwr_mode_dp
  import pwr_mode_pkg::*;
#(
  parameter int IRQ_W       = 16,
  parameter int KIN_W       = 16,
  parameter int WUE_W       = 8,
  parameter int RST_MIN_CYC = 20
) (
  input  logic             clk,
  input  logic             rstPinN,
  input  dpCtl_t           ctl,
  input  logic [2:0]       settleSel,
  input  logic             nmi,
  input  logic [IRQ_W-1:0] irqReq,
  input  logic [IRQ_W-1:0] irqEn,
  input  logic [KIN_W-1:0] kinReq,
  input  logic [KIN_W-1:0] kinEn,
  input  logic [WUE_W-1:0] wueReq,
  input  logic [WUE_W-1:0] wueEn,
  input  logic             kbdIrq,
  input  logic             periphIrq,
  input  logic             cpuMaskAll,
  output logic             sleepWake,
  output logic             stbyWake,
  output logic             settleDone,
  output logic             rstLongEnough
);

  localparam int RST_W = $clog2(RST_MIN_CYC + 1);
  localparam logic [RST_W-1:0] RST_LIMIT = RST_W'(RST_MIN_CYC);

  logic                extGroup;
  logic [SETTLE_W-1:0] settleCnt;
  logic [RST_W-1:0]    rstCnt;

  // external sources, each behind its own enable, all maskable
  assign extGroup  = (|(irqReq & irqEn)) | (|(kinReq & kinEn)) |
                     (|(wueReq & wueEn)) | kbdIrq;
  assign stbyWake  = nmi | (!cpuMaskAll & extGroup);
  assign sleepWake = stbyWake | (!cpuMaskAll & periphIrq);

  // oscillator settling down-counter
  always_ff @(posedge clk) begin
    if (ctl.settleLoad)
      settleCnt <= settleCycles(settleSel);
    else if (ctl.settleDec)
      settleCnt <= settleCnt - SETTLE_W'(1);
  end
  assign settleDone = (settleCnt == SETTLE_W'(1));

  // reset-pin low-time counter, saturating at the minimum
  always_ff @(posedge clk) begin
    if (ctl.rstStart)
      rstCnt <= RST_W'(1);
    else if (ctl.rstInc) begin
      if (rstCnt < RST_LIMIT)
        rstCnt <= rstCnt + RST_W'(1);
    end else if (ctl.rstClr)
      rstCnt <= '0;
  end
  assign rstLongEnough = (rstCnt >= RST_LIMIT);

  // R5: the countdown never decrements through zero
  assert_settle_nonzero_R5: assert property (@(posedge clk) disable iff (!rstPinN)
    ctl.settleDec |-> (settleCnt > SETTLE_W'(1)));

  // R5: a load is followed by a count that matches the select code
  assert_settle_load_R5: assert property (@(posedge clk) disable iff (!rstPinN)
    ctl.settleLoad |=> (settleCnt == settleCycles($past(settleSel))));

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic   clk,
  input  logic   rstPinN,
  input  logic   sleepReq,
  input  logic   stbySel,
  input  logic   lowSpdSel,
  input  logic   wdtPssSel,
  input  logic   sleepWake,
  input  logic   stbyWake,
  input  logic   settleDone,
  input  logic   rstLongEnough,
  output dpCtl_t ctl,
  output logic   cpuClkEn,
  output logic   perClkEn,
  output logic   oscEn,
  output logic   perRstPulse,
  output logic   wakeStart
);

  pwrState_e state, nextState;
  logic      pickSleep, pickStby;

  assign pickSleep = !stbySel && !lowSpdSel;
  assign pickStby  = stbySel && !lowSpdSel && !wdtPssSel;

  always_comb begin
    nextState = state;
    ctl       = '0;
    if (!rstPinN) begin
      nextState = ST_RESET;
      if (state == ST_RESET) ctl.rstInc   = 1'b1;
      else                   ctl.rstStart = 1'b1;
    end else begin
      case (state)
        ST_RUN: begin
          if (sleepReq && pickSleep)     nextState = ST_SLEEP;
          else if (sleepReq && pickStby) nextState = ST_STBY;
        end
        ST_SLEEP: if (sleepWake) nextState = ST_RUN;
        ST_STBY: begin
          if (stbyWake) begin
            nextState      = ST_SETTLE;
            ctl.settleLoad = 1'b1;
          end
        end
        ST_SETTLE: begin
          if (settleDone) nextState = ST_RUN;
          else            ctl.settleDec = 1'b1;
        end
        ST_RESET: begin
          ctl.rstClr = 1'b1;
          if (rstLongEnough) nextState = ST_RUN;
        end
        default: nextState = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    state       <= nextState;
    wakeStart   <= (nextState == ST_RUN) && (state != ST_RUN);
    perRstPulse <= (nextState == ST_STBY) && (state != ST_STBY);
  end

  assign cpuClkEn = (state == ST_RUN);
  assign perClkEn = (state != ST_STBY) && (state != ST_SETTLE);
  assign oscEn    = (state != ST_STBY);

  assert_wake_single_R7: assert property (@(posedge clk) disable iff (!rstPinN)
    wakeStart |=> !wakeStart);

  assert_wake_with_clk_R7: assert property (@(posedge clk) disable iff (!rstPinN)
    $rose(cpuClkEn) |-> wakeStart);

  assert_perrst_single_R3: assert property (@(posedge clk) disable iff (!rstPinN)
    perRstPulse |=> !perRstPulse);

  assert_perrst_in_stby_R9: assert property (@(posedge clk) disable iff (!rstPinN)
    perRstPulse |-> (!oscEn && !cpuClkEn));

  assert_osc_off_gates_R3: assert property (@(posedge clk) disable iff (!rstPinN)
    !oscEn |-> (!cpuClkEn && !perClkEn));

  assert_settle_ends_R5: assert property (@(posedge clk) disable iff (!rstPinN)
    (state == ST_SETTLE && settleDone) |=> cpuClkEn);

  assert_ignored_cfg_R6: assert property (@(posedge clk) disable iff (!rstPinN)
    (cpuClkEn && sleepReq && lowSpdSel) |=> cpuClkEn);

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int IRQ_W       = 16,
  parameter int KIN_W       = 16,
  parameter int WUE_W       = 8,
  parameter int RST_MIN_CYC = 20
) (
  input  logic             clk,
  input  logic             rstPinN,
  input  logic             sleepReq,
  input  logic             stbySel,
  input  logic             lowSpdSel,
  input  logic             wdtPssSel,
  input  logic [2:0]       settleSel,
  input  logic             nmi,
  input  logic [IRQ_W-1:0] irqReq,
  input  logic [IRQ_W-1:0] irqEn,
  input  logic [KIN_W-1:0] kinReq,
  input  logic [KIN_W-1:0] kinEn,
  input  logic [WUE_W-1:0] wueReq,
  input  logic [WUE_W-1:0] wueEn,
  input  logic             kbdIrq,
  input  logic             periphIrq,
  input  logic             cpuMaskAll,
  output logic             cpuClkEn,
  output logic             perClkEn,
  output logic             oscEn,
  output logic             perRstPulse,
  output logic             wakeStart
);

  dpCtl_t ctl;
  logic   sleepWake, stbyWake, settleDone, rstLongEnough;

  pwr_mode_fsm u_fsm (
    .clk           (clk),
    .rstPinN       (rstPinN),
    .sleepReq      (sleepReq),
    .stbySel       (stbySel),
    .lowSpdSel     (lowSpdSel),
    .wdtPssSel     (wdtPssSel),
    .sleepWake     (sleepWake),
    .stbyWake      (stbyWake),
    .settleDone    (settleDone),
    .rstLongEnough (rstLongEnough),
    .ctl           (ctl),
    .cpuClkEn      (cpuClkEn),
    .perClkEn      (perClkEn),
    .oscEn         (oscEn),
    .perRstPulse   (perRstPulse),
    .wakeStart     (wakeStart)
  );

  pwr_mode_dp #(
    .IRQ_W       (IRQ_W),
    .KIN_W       (KIN_W),
    .WUE_W       (WUE_W),
    .RST_MIN_CYC (RST_MIN_CYC)
  ) u_dp (
    .clk           (clk),
    .rstPinN       (rstPinN),
    .ctl           (ctl),
    .settleSel     (settleSel),
    .nmi           (nmi),
    .irqReq        (irqReq),
    .irqEn         (irqEn),
    .kinReq        (kinReq),
    .kinEn         (kinEn),
    .wueReq        (wueReq),
    .wueEn         (wueEn),
    .kbdIrq        (kbdIrq),
    .periphIrq     (periphIrq),
    .cpuMaskAll    (cpuMaskAll),
    .sleepWake     (sleepWake),
    .stbyWake      (stbyWake),
    .settleDone    (settleDone),
    .rstLongEnough (rstLongEnough)
  );

endmodule

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
  localparam int IRQ_W   = 16;
  localparam int KIN_W   = 16;
  localparam int WUE_W   = 8;
  localparam int RST_MIN = 20;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rstPinN, sleepReq, stbySel, lowSpdSel, wdtPssSel;
  logic [2:0]       settleSel;
  logic             nmi, kbdIrq, periphIrq, cpuMaskAll;
  logic [IRQ_W-1:0] irqReq, irqEn;
  logic [KIN_W-1:0] kinReq, kinEn;
  logic [WUE_W-1:0] wueReq, wueEn;
  logic             cpuClkEn, perClkEn, oscEn, perRstPulse, wakeStart;

  pwr_mode_ctrl #(.IRQ_W(IRQ_W), .KIN_W(KIN_W), .WUE_W(WUE_W), .RST_MIN_CYC(RST_MIN)) uut (
    .clk(clk), .rstPinN(rstPinN), .sleepReq(sleepReq), .stbySel(stbySel),
    .lowSpdSel(lowSpdSel), .wdtPssSel(wdtPssSel), .settleSel(settleSel), .nmi(nmi),
    .irqReq(irqReq), .irqEn(irqEn), .kinReq(kinReq), .kinEn(kinEn),
    .wueReq(wueReq), .wueEn(wueEn), .kbdIrq(kbdIrq), .periphIrq(periphIrq),
    .cpuMaskAll(cpuMaskAll), .cpuClkEn(cpuClkEn), .perClkEn(perClkEn), .oscEn(oscEn),
    .perRstPulse(perRstPulse), .wakeStart(wakeStart)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  // advance one edge, land clear of it
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic clearWake();
    nmi = 0; kbdIrq = 0; periphIrq = 0;
    irqReq = '0; kinReq = '0; wueReq = '0;
  endtask

  function automatic int settleLen(input logic [2:0] sel);
    if (sel == 3'd7) return 16;
    if (sel == 3'd6) return 2048;
    return 8192 << sel;
  endfunction

  // expected wake decision from the requirement text (R2, R4)
  function automatic bit expWake(input bit inStby);
    bit grp;
    grp = (|(irqReq & irqEn)) || (|(kinReq & kinEn)) || (|(wueReq & wueEn)) || kbdIrq;
    if (!inStby) grp = grp || periphIrq;
    return nmi || (!cpuMaskAll && grp);
  endfunction

  // 0 = ignored, 1 = sleep, 2 = standby (R1, R3, R6)
  function automatic int expMode(input bit s, input bit l, input bit p);
    if (!s && !l) return 1;
    if (s && !l && !p) return 2;
    return 0;
  endfunction

  task automatic issueSleep(input bit s, input bit l, input bit p);
    stbySel = s; lowSpdSel = l; wdtPssSel = p;
    sleepReq = 1; tick(); sleepReq = 0;
  endtask

  // called right after the edge that saw the standby wake
  task automatic finishSettle(input logic [2:0] sel);
    chk("R5 osc restarts", oscEn, 1);
    chk("R5 cpu held during settle", cpuClkEn, 0);
    clearWake();
    repeat (settleLen(sel) - 1) tick();
    chk("R5 cpu still off at last settle cycle", cpuClkEn, 0);
    chk("R5 per still off at last settle cycle", perClkEn, 0);
    tick();
    chk("R5 cpu back after settle", cpuClkEn, 1);
    chk("R7 wakeStart with cpu clock", wakeStart, 1);
    tick();
    chk("R7 wakeStart single cycle", wakeStart, 0);
  endtask

  initial begin
    #1_800_000;
    nChecks++;
    nFails++;
    $display("FAIL R5 watchdog: actual hung expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd7331));
    rstPinN = 0; sleepReq = 0; stbySel = 0; lowSpdSel = 0; wdtPssSel = 0;
    settleSel = 3'd7; cpuMaskAll = 0;
    irqEn = '0; kinEn = '0; wueEn = '0;
    clearWake();

    // reset state and release
    repeat (RST_MIN + 3) tick();
    chk("R8 cpu off in reset", cpuClkEn, 0);
    chk("R8 per on in reset", perClkEn, 1);
    chk("R8 osc on in reset", oscEn, 1);
    chk("R9 no perRst in reset", perRstPulse, 0);
    rstPinN = 1; tick();
    chk("R8 run after release", cpuClkEn, 1);
    chk("R7 wakeStart after reset", wakeStart, 1);
    tick();
    chk("R7 wakeStart drops", wakeStart, 0);

    // reset one cycle short of the minimum is not accepted
    rstPinN = 0; repeat (RST_MIN - 1) tick();
    rstPinN = 1; repeat (3) tick();
    chk("R8 short reset holds core", cpuClkEn, 0);
    rstPinN = 0; repeat (RST_MIN) tick();
    rstPinN = 1; tick();
    chk("R8 exact minimum releases", cpuClkEn, 1);
    chk("R7 wakeStart on exact minimum", wakeStart, 1);
    tick();

    // long settling codes, woken by nmi under full mask
    for (int k = 0; k < 2; k++) begin
      settleSel = 3'(k);
      issueSleep(1, 0, 0);
      chk("R3 perRst on entry", perRstPulse, 1);
      chk("R3 osc off", oscEn, 0);
      tick();
      chk("R3 perRst single cycle", perRstPulse, 0);
      cpuMaskAll = 1; nmi = 1; tick();
      cpuMaskAll = 0;
      finishSettle(settleSel);
    end

    // reset during standby
    issueSleep(1, 0, 0);
    rstPinN = 0; tick();
    chk("R8 reset from standby cpu", cpuClkEn, 0);
    chk("R8 reset from standby per", perClkEn, 1);
    chk("R8 reset from standby osc", oscEn, 1);
    repeat (RST_MIN - 1) tick();
    rstPinN = 1; tick();
    chk("R8 run after standby reset", cpuClkEn, 1);
    tick();

    // random trials
    for (int t = 0; t < 90; t++) begin
      int cfgKind, m, kind, idx;
      bit s, l, p, e;
      cfgKind = int'($urandom % 4);
      if (cfgKind == 0)      begin s = 0; l = 0; p = 1'($urandom); end
      else if (cfgKind == 1) begin s = 1; l = 0; p = 0; end
      else begin s = 1'($urandom); l = 1'($urandom); p = 1'($urandom); end
      m = expMode(s, l, p);
      settleSel = ($urandom % 2 == 0) ? 3'd7 : 3'd6;
      issueSleep(s, l, p);
      if (m == 0) begin
        chk("R6 ignored request keeps cpu", cpuClkEn, 1);
        chk("R6 ignored request no perRst", perRstPulse, 0);
        continue;
      end
      if (m == 1) begin
        chk("R1 sleep cpu off", cpuClkEn, 0);
        chk("R1 sleep per on", perClkEn, 1);
        chk("R1 sleep osc on", oscEn, 1);
        chk("R9 no perRst on sleep", perRstPulse, 0);
      end else begin
        chk("R3 standby clocks off", {cpuClkEn, perClkEn, oscEn}, 0);
        chk("R3 perRst on entry", perRstPulse, 1);
        tick();
        chk("R3 perRst single cycle", perRstPulse, 0);
      end

      kind = int'($urandom % 8);
      idx  = int'($urandom % 16);
      cpuMaskAll = ($urandom % 3 == 0);
      irqEn = 16'($urandom); kinEn = 16'($urandom); wueEn = 8'($urandom);
      case (kind)
        1: nmi = 1;
        2: irqReq[idx] = 1;
        3: kinReq[idx] = 1;
        4: wueReq[idx % WUE_W] = 1;
        5: kbdIrq = 1;
        6: periphIrq = 1;
        7: begin irqReq = 16'($urandom); irqEn = ~irqReq; end
        default: ;
      endcase
      e = expWake(m == 2);
      tick();
      if (!e) begin
        chk(m == 2 ? "R4 no wake stays in standby" : "R2 no wake stays in sleep", cpuClkEn, 0);
        chk(m == 2 ? "R4 osc stays off" : "R2 osc stays on", oscEn, (m == 2) ? 0 : 1);
        clearWake(); cpuMaskAll = 0; nmi = 1; tick();
      end
      if (m == 1) begin
        chk("R2 sleep wake", cpuClkEn, 1);
        chk("R7 wakeStart after sleep", wakeStart, 1);
        clearWake(); tick();
        chk("R7 wakeStart single cycle", wakeStart, 0);
      end else begin
        finishSettle(settleSel);
      end
      cpuMaskAll = 0;
    end

    finishRun();
  end
endmodule